// File: doc/BRIEF.md
# Shadow-Set Interrupt Preemption Arbiter

This block decides, every clock cycle, whether one of the pending external interrupt lines may interrupt the code that is running. When one may, it picks that line and reports which handler register set the handler will use. Software gives each line a priority level from 1 to 7 and a register set number. A level of 0 turns the line off. The processor supplies its current level, its current register set, a global interrupt enable and a same-set preemption enable. The block compares every pending line against these inputs. It then emits a one-cycle take pulse together with the winning line's index, level and target set.

An interrupt that targets a register set other than the one in use needs only a level above the current level. An interrupt that targets the set already in use must also have the same-set preemption enable raised. Without that enable it waits until the running handler finishes, however high its level. Set 0 is the normal register set, the one that non-interrupt exceptions always use. A line assigned to set 0 is reported with target set 0.

The block also examines the configuration continuously. For each register set it forms the span from the lowest to the highest enabled level assigned to that set. It raises an error flag whenever the spans of two different sets intersect.

Top module: `shadow_preempt_arbiter`

## Requirements
- R1: After reset, takeStrobe, takeIdx, takeLevel, takeSet and overlapErr are 0, and every line's configured level is 0, so no line can be taken until it is configured.
- R2: With cfgWe high at a rising edge, line cfgIdx takes level cfgLevel and set cfgSet. The new values govern arbitration from the next cycle on.
- R3: A line whose configured level is 0 is never taken, even when it is pending.
- R4: While globalEn is 0, takeStrobe stays 0.
- R5: A line is eligible only when its level is strictly greater than curLevel (levels 1 to 7, a larger value means higher priority).
- R6: A pending line whose set differs from curSet is taken when globalEn is 1 and its level exceeds curLevel, whatever setPreemptEn is.
- R7: While setPreemptEn is 0, a line whose set equals curSet is not taken at any level.
- R8: While setPreemptEn is 1, a line whose set equals curSet is taken when its level exceeds curLevel.
- R9: Among eligible lines, the line with the highest level wins. When levels tie, the lowest line index wins.
- R10: takeStrobe rises at the rising edge after the inputs that make a line eligible. takeIdx, takeLevel and takeSet are loaded at that same edge and keep their values while takeStrobe is 0. takeStrobe is never high on two consecutive cycles.
- R11: overlapErr is 1, one cycle after the configuration changes, exactly when two different sets both have enabled lines and their level spans [min,max] intersect. It is independent of globalEn.
- R12: takeSet equals the configured set of the winning line. Set 0 is reported as 0, meaning the normal register set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgIdx | input | 3 | Line number being configured |
| cfgLevel | input | 3 | Level to store for that line (0 turns it off) |
| cfgSet | input | 2 | Register set to store for that line |
| irqPending | input | 8 | Pending interrupt lines |
| globalEn | input | 1 | Global interrupt enable |
| curLevel | input | 3 | Level of the running code |
| curSet | input | 2 | Register set currently in use |
| setPreemptEn | input | 1 | Allows preemption within the current set |
| takeStrobe | output | 1 | One-cycle pulse: an interrupt is taken |
| takeIdx | output | 3 | Winning line index |
| takeLevel | output | 3 | Winning line level |
| takeSet | output | 2 | Winning line target register set |
| overlapErr | output | 1 | Level spans of different sets intersect |

## Verification
On every cycle the assertions check the local rules of each take. A take never follows a cycle with globalEn low. Its level is above the level seen in the previous cycle. It never lands in the set that was in use while same-set preemption was off. Its line was pending. Strobes never come back to back, and the reported fields hold between takes. Whether the winner really had the highest level with the lowest index, whether eligible lines were missed, and whether overlapErr matches the level spans can only be shown by the bench. It sweeps levels, sets, enables and pending patterns over fixed and pseudo-random configurations and compares every result against an independent arithmetic model.

// File: rtl/spa_pkg.sv
package spa_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic loadTake;   // capture the current winner into the output registers
  } ctrl_t;
endpackage

// File: rtl/spa_cfg_regs.sv
module spa_cfg_regs #(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int SET_W = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [IDX_W-1:0]            cfgIdx,
  input  logic [LVL_W-1:0]            cfgLevel,
  input  logic [SET_W-1:0]            cfgSet,
  output logic [N-1:0][LVL_W-1:0]     rilQ,
  output logic [N-1:0][SET_W-1:0]     setQ
);
  // One level/set register pair per line.
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rilQ[i] <= '0;
        setQ[i] <= '0;
      end else if (cfgWe && (cfgIdx == IDX_W'(i))) begin
        rilQ[i] <= cfgLevel;
        setQ[i] <= cfgSet;
      end
    end
  end
endmodule

// File: rtl/spa_overlap.sv
module spa_overlap #(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int SET_W = 2,
  localparam int NSETS = 1 << SET_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [N-1:0][LVL_W-1:0] rilQ,
  input  logic [N-1:0][SET_W-1:0] setQ,
  output logic                    overlapErr
);
  logic [NSETS-1:0]            used;
  logic [NSETS-1:0][LVL_W-1:0] lo;
  logic [NSETS-1:0][LVL_W-1:0] hi;
  logic                        ovNext;

  // Level span of each register set, over the lines that are switched on.
  always_comb begin
    for (int s = 0; s < NSETS; s++) begin
      used[s] = 1'b0;
      lo[s]   = '1;
      hi[s]   = '0;
      for (int i = 0; i < N; i++) begin
        if ((rilQ[i] != '0) && (setQ[i] == SET_W'(s))) begin
          used[s] = 1'b1;
          if (rilQ[i] < lo[s]) lo[s] = rilQ[i];
          if (rilQ[i] > hi[s]) hi[s] = rilQ[i];
        end
      end
    end
  end

  // Pairwise interval intersection between distinct sets.
  always_comb begin
    ovNext = 1'b0;
    for (int s = 0; s < NSETS; s++) begin
      for (int t = s + 1; t < NSETS; t++) begin
        if (used[s] && used[t] && (lo[s] <= hi[t]) && (lo[t] <= hi[s]))
          ovNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overlapErr <= 1'b0;
    else       overlapErr <= ovNext;
  end
endmodule

// File: rtl/spa_datapath.sv
module spa_datapath
  import spa_pkg::*;
#(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int SET_W = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [N-1:0][LVL_W-1:0] rilQ,
  input  logic [N-1:0][SET_W-1:0] setQ,
  input  logic [N-1:0]            irqPending,
  input  logic [LVL_W-1:0]        curLevel,
  input  logic [SET_W-1:0]        curSet,
  input  logic                    setPreemptEn,
  input  ctrl_t                   ctrl,
  output logic                    anyElig,
  output logic [IDX_W-1:0]        takeIdx,
  output logic [LVL_W-1:0]        takeLevel,
  output logic [SET_W-1:0]        takeSet
);
  logic [N-1:0]       elig;
  logic [IDX_W-1:0]   bestIdx;
  logic [LVL_W-1:0]   bestLvl;
  logic [SET_W-1:0]   bestSet;
  logic               found;

  // Per-line eligibility: enabled, above current level, and either a
  // different register set or same-set preemption allowed.
  for (genvar i = 0; i < N; i++) begin : g_elig
    logic sameSet;
    assign sameSet = (setQ[i] == curSet);
    assign elig[i] = irqPending[i] && (rilQ[i] != '0) &&
                     (rilQ[i] > curLevel) && (!sameSet || setPreemptEn);
  end

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    bestSet = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!found || (rilQ[i] >= bestLvl))) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestLvl = rilQ[i];
        bestSet = setQ[i];
      end
    end
  end

  assign anyElig = found;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIdx   <= '0;
      takeLevel <= '0;
      takeSet   <= '0;
    end else if (ctrl.loadTake) begin
      takeIdx   <= bestIdx;
      takeLevel <= bestLvl;
      takeSet   <= bestSet;
    end
  end
endmodule

// File: rtl/spa_ctrl.sv
module spa_ctrl
  import spa_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  anyElig,
  input  logic  globalEn,
  output ctrl_t ctrl,
  output logic  takeStrobe
);
  // A take needs the global enable; the cycle after a take is held off so
  // the processor status can move to the new level before the next decision.
  assign ctrl.loadTake = anyElig && globalEn && !takeStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) takeStrobe <= 1'b0;
    else       takeStrobe <= ctrl.loadTake;
  end
endmodule

// File: rtl/shadow_preempt_arbiter.sv
module shadow_preempt_arbiter
  import spa_pkg::*;
#(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int SET_W = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [LVL_W-1:0] cfgLevel,
  input  logic [SET_W-1:0] cfgSet,
  input  logic [N-1:0]     irqPending,
  input  logic             globalEn,
  input  logic [LVL_W-1:0] curLevel,
  input  logic [SET_W-1:0] curSet,
  input  logic             setPreemptEn,
  output logic             takeStrobe,
  output logic [IDX_W-1:0] takeIdx,
  output logic [LVL_W-1:0] takeLevel,
  output logic [SET_W-1:0] takeSet,
  output logic             overlapErr
);
  logic [N-1:0][LVL_W-1:0] rilQ;
  logic [N-1:0][SET_W-1:0] setQ;
  logic                    anyElig;
  ctrl_t                   ctrl;

  spa_cfg_regs #(.N(N), .LVL_W(LVL_W), .SET_W(SET_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgLevel(cfgLevel), .cfgSet(cfgSet), .rilQ(rilQ), .setQ(setQ)
  );

  spa_datapath #(.N(N), .LVL_W(LVL_W), .SET_W(SET_W)) u_dp (
    .clk(clk), .rstN(rstN), .rilQ(rilQ), .setQ(setQ),
    .irqPending(irqPending), .curLevel(curLevel), .curSet(curSet),
    .setPreemptEn(setPreemptEn), .ctrl(ctrl), .anyElig(anyElig),
    .takeIdx(takeIdx), .takeLevel(takeLevel), .takeSet(takeSet)
  );

  spa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyElig(anyElig), .globalEn(globalEn),
    .ctrl(ctrl), .takeStrobe(takeStrobe)
  );

  spa_overlap #(.N(N), .LVL_W(LVL_W), .SET_W(SET_W)) u_ov (
    .clk(clk), .rstN(rstN), .rilQ(rilQ), .setQ(setQ), .overlapErr(overlapErr)
  );
endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int SET_W = 2,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rstN,
  input logic [N-1:0]     irqPending,
  input logic             globalEn,
  input logic [LVL_W-1:0] curLevel,
  input logic [SET_W-1:0] curSet,
  input logic             setPreemptEn,
  input logic             takeStrobe,
  input logic [IDX_W-1:0] takeIdx,
  input logic [LVL_W-1:0] takeLevel,
  input logic [SET_W-1:0] takeSet
);
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> $past(globalEn));

  assert_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> (takeLevel > $past(curLevel)));

  assert_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> (takeLevel != '0));

  assert_sameset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (takeStrobe && (takeSet == $past(curSet))) |-> $past(setPreemptEn));

  assert_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> (|(($past(irqPending) >> takeIdx) & N'(1))));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |=> !takeStrobe);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !takeStrobe |-> ($stable(takeIdx) && $stable(takeLevel) && $stable(takeSet)));
endmodule

bind shadow_preempt_arbiter spa_checker #(.N(N), .LVL_W(LVL_W), .SET_W(SET_W)) u_chk (
  .clk(clk), .rstN(rstN), .irqPending(irqPending), .globalEn(globalEn),
  .curLevel(curLevel), .curSet(curSet), .setPreemptEn(setPreemptEn),
  .takeStrobe(takeStrobe), .takeIdx(takeIdx), .takeLevel(takeLevel),
  .takeSet(takeSet)
);

// File: tb/sim_shadow_preempt_arbiter.sv
module sim_shadow_preempt_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [2:0] cfgLevel = '0;
  logic [1:0] cfgSet = '0;
  logic [7:0] irqPending = '0;
  logic       globalEn = 1'b0;
  logic [2:0] curLevel = '0;
  logic [1:0] curSet = '0;
  logic       setPreemptEn = 1'b0;
  logic       takeStrobe;
  logic [2:0] takeIdx;
  logic [2:0] takeLevel;
  logic [1:0] takeSet;
  logic       overlapErr;

  int nChecks = 0;
  int nErr = 0;
  int mRil[8];
  int mSet[8];
  int lastIdx = 0, lastLvl = 0, lastSet = 0;
  logic [31:0] seed = 32'h1234_5678;

  shadow_preempt_arbiter u0 (.*);

  always #2 clk = ~clk;  // 250 MHz

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCfg(input int idx, input int lvl, input int st);
    cfgWe = 1'b1; cfgIdx = 3'(idx); cfgLevel = 3'(lvl); cfgSet = 2'(st);
    tick();
    cfgWe = 1'b0;
    mRil[idx] = lvl;
    mSet[idx] = st;
  endtask

  function automatic int expOverlap();
    int lo[4], hi[4];
    bit used[4];
    int r = 0;
    for (int s = 0; s < 4; s++) begin used[s] = 0; lo[s] = 99; hi[s] = -1; end
    for (int i = 0; i < 8; i++) begin
      if (mRil[i] != 0) begin
        used[mSet[i]] = 1;
        if (mRil[i] < lo[mSet[i]]) lo[mSet[i]] = mRil[i];
        if (mRil[i] > hi[mSet[i]]) hi[mSet[i]] = mRil[i];
      end
    end
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
        if (s != t && used[s] && used[t] && !(hi[s] < lo[t] || hi[t] < lo[s])) r = 1;
    return r;
  endfunction

  // Winner per R5..R9: strict ">" while scanning upward keeps the lowest index on ties.
  function automatic int expWinner(input int pend, input int cl, input int cs, input int pe);
    int best = -1;
    for (int i = 0; i < 8; i++) begin
      if (((pend >> i) & 1) != 0 && mRil[i] > cl && (mSet[i] != cs || pe != 0))
        if (best < 0 || mRil[i] > mRil[best]) best = i;
    end
    return best;
  endfunction

  // Drive one vector, check the registered result, then one idle cycle.
  task automatic runVec(input int pend, input int cl, input int cs, input int pe, input int ge);
    int w;
    bit expTake;
    irqPending = 8'(pend); curLevel = 3'(cl); curSet = 2'(cs);
    setPreemptEn = 1'(pe); globalEn = 1'(ge);
    w = expWinner(pend, cl, cs, pe);
    expTake = (ge != 0) && (w >= 0);
    tick();
    chk(takeStrobe == expTake, ge == 0 ? "R4 strobe gated" : "R5 R6 R7 R8 strobe",
        int'(takeStrobe), int'(expTake));
    if (expTake) begin
      lastIdx = w; lastLvl = mRil[w]; lastSet = mSet[w];
      chk(takeIdx == 3'(w) && takeLevel == 3'(mRil[w]), "R9 winner idx/level",
          int'(takeIdx) * 10 + int'(takeLevel), w * 10 + mRil[w]);
      chk(takeSet == 2'(mSet[w]), "R12 target set", int'(takeSet), mSet[w]);
    end else begin
      chk(takeIdx == 3'(lastIdx) && takeLevel == 3'(lastLvl) && takeSet == 2'(lastSet),
          "R10 fields hold", int'(takeIdx), lastIdx);
    end
    irqPending = '0;
    tick();
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mRil[i] = 0; mSet[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, R3 all lines off
    chk(takeStrobe == 0 && takeIdx == 0 && takeLevel == 0 && takeSet == 0 && overlapErr == 0,
        "R1 reset outputs", int'(takeStrobe), 0);
    irqPending = 8'hff; globalEn = 1'b1;
    tick();
    chk(takeStrobe == 0, "R1 R3 unconfigured lines not taken", int'(takeStrobe), 0);
    irqPending = '0;
    tick();

    // Fixed legal layout: set1 levels 1..3, set2 levels 4..7, line 7 level 3 in set1.
    writeCfg(0, 1, 1); writeCfg(1, 2, 1); writeCfg(2, 3, 1); writeCfg(3, 4, 2);
    writeCfg(4, 5, 2); writeCfg(5, 6, 2); writeCfg(6, 7, 2); writeCfg(7, 3, 1);
    tick();
    chk(overlapErr == 1'(expOverlap()), "R11 legal layout", int'(overlapErr), expOverlap());

    // R2: write takes effect on the very next cycle.
    writeCfg(0, 7, 3);
    runVec(8'h01, 6, 0, 0, 1);
    chk(lastIdx == 0 && lastSet == 3, "R2 new config used", lastSet, 3);
    writeCfg(0, 1, 1);

    // Sweep of state space over the fixed layout.
    for (int cl = 0; cl < 8; cl++)
      for (int cs = 0; cs < 4; cs++)
        for (int pe = 0; pe < 2; pe++)
          for (int ge = 0; ge < 2; ge++)
            for (int p = 0; p < 6; p++) begin
              int pat;
              case (p)
                0: pat = 8'hff; 1: pat = 8'h01; 2: pat = 8'h80;
                3: pat = 8'haa; 4: pat = 8'h55; default: pat = 8'h84;
              endcase
              runVec(pat, cl, cs, pe, ge);
            end

    // R7 / R8 targeted: line 6 (level 7, set 2) pending, running in set 2 at level 4.
    runVec(8'h40, 4, 2, 0, 1);
    chk(takeStrobe == 0, "R7 same set blocked at level 7", int'(takeStrobe), 0);
    runVec(8'h40, 4, 2, 1, 1);
    chk(lastIdx == 6, "R8 same set preempts when enabled", lastIdx, 6);
    // R6: different set taken with preemption disabled.
    runVec(8'h40, 4, 1, 0, 1);
    chk(lastIdx == 6, "R6 other set taken", lastIdx, 6);

    // R9 tie: lines 2 and 7 both level 3 set1 -> index 2.
    runVec(8'h84, 0, 0, 0, 1);
    chk(lastIdx == 2, "R9 tie lowest index", lastIdx, 2);

    // R12: a line in set 0 reports set 0.
    writeCfg(3, 4, 0);
    runVec(8'h08, 0, 2, 0, 1);
    chk(lastSet == 0 && lastIdx == 3, "R12 normal set reported", lastSet, 0);
    writeCfg(3, 4, 2);

    // R10 holdoff: pending held three cycles gives strobes 1,0,1.
    irqPending = 8'h20; curLevel = 0; curSet = 0; setPreemptEn = 0; globalEn = 1;
    tick();
    chk(takeStrobe == 1, "R10 first pulse", int'(takeStrobe), 1);
    tick();
    chk(takeStrobe == 0, "R10 no back-to-back", int'(takeStrobe), 0);
    tick();
    chk(takeStrobe == 1, "R10 pulse after holdoff", int'(takeStrobe), 1);
    irqPending = '0;
    tick();
    lastIdx = 5; lastLvl = 6; lastSet = 2;

    // R11: overlapping layout, flag independent of globalEn.
    globalEn = 1'b0;
    writeCfg(7, 5, 1);
    chk(overlapErr == 0, "R11 flag one cycle late", int'(overlapErr), 0);
    tick();
    chk(overlapErr == 1, "R11 overlap with enable off", int'(overlapErr), 1);
    writeCfg(7, 0, 1);
    tick();
    chk(overlapErr == 0, "R11 overlap cleared by disabling line", int'(overlapErr), 0);

    // Pseudo-random layouts and vectors.
    for (int c = 0; c < 30; c++) begin
      for (int i = 0; i < 8; i++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        writeCfg(i, int'(seed[18:16]), int'(seed[21:20]));
      end
      tick();
      chk(overlapErr == 1'(expOverlap()), "R11 random layout", int'(overlapErr), expOverlap());
      for (int v = 0; v < 32; v++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        runVec(int'(seed[23:16]), int'(seed[26:24]), int'(seed[28:27]),
               int'(seed[29]), int'(seed[30] | seed[31]));
      end
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule